// File: doc/BRIEF.md
# Watermark-Gated Interrupt Controller

This block owns the interrupt status and mask of a packet interface and drives a single interrupt line towards the CPU. Interrupt causes arrive as bit vectors on an event input and are accumulated in the status register. The CPU reaches status, mask, configuration and command through a small register port. Status is cleared by writing ones.

Two causes, receive-high and transmit-low, are gated by FIFO history. Receive-high only reaches the line after the receive FIFO has been seen empty. Transmit-low only reaches the line after the transmit FIFO has been seen full. Each arming is consumed by one delivery. Causes outside the no-delay group are coalesced: the line is raised a programmable number of cycles after the first request, and later requests ride on the earlier deadline. A pending flag keeps the line up until the masked status becomes zero, and a second assertion is not issued while one is outstanding.

Register map (2-bit address): 0 status (write-one-to-clear), 1 mask, 2 config (bit 0 = interrupt enable, bits 7:1 = delay in cycles), 3 command (bit 0 = post software interrupt; reads as 0). Status bits: 0 software, 1 receive-high, 2 receive-packet, 3 transmit-low, 4 receive-DMA, 5 transmit-packet, 6 transmit-full, 7 reserved. The no-delay group is bits 0 and 6.

Top module: `wm_intr_ctrl`

## Requirements
- R1: After reset status reads 0x00, mask reads 0x0F, config reads 0x00 and irq_o is low; an accepted event ORs its bits into status.
- R2: An event or a status write that has bit 7 set is ignored entirely (status unchanged) and bad_o is high in the cycle after the request.
- R3: Receive-high (bit 1) is removed from the effective set unless rx_empty_i has been high since the last time it was delivered; a delivery consumes the arming.
- R4: Transmit-low (bit 3) is removed from the effective set unless tx_full_i has been high since the last time it was delivered; a delivery consumes the arming.
- R5: A post whose effective set (status AND mask, after gating) has no no-delay bit raises irq_o exactly d clock edges after the posting edge, d = config[7:1]; d = 0 raises it on the posting edge.
- R6: A post whose effective set holds bit 0 or bit 6 raises irq_o on the posting edge.
- R7: A delayed post made while a deadline is already running does not move that deadline.
- R8: A status write clears exactly the bits written as one; when status AND mask becomes zero, irq_o falls on that edge and any running deadline is cancelled.
- R9: A mask write with a new value that makes status AND mask nonzero raises irq_o on that edge; writing the current mask value changes nothing.
- R10: While config bit 0 is low, posts do not raise irq_o; clearing the bit drops irq_o; setting it while status AND mask is nonzero raises irq_o on that edge.
- R11: A command write with bit 0 set posts the software interrupt (status bit 0).
- R12: While irq_o is high, further posts leave it high and it stays high as long as status AND mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event post strobe |
| evt_bits_i | input | 8 | Interrupt bits to post |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| rx_empty_i | input | 1 | Receive FIFO is empty |
| tx_full_i | input | 1 | Transmit FIFO is full |
| irq_o | output | 1 | Interrupt line to the CPU |
| bad_o | output | 1 | Reserved-bit request was rejected |

## Verification
The assertions assume that an event post and a register write never share a cycle when they judge status stability or write-one-to-clear results, and that the same-mask property is only judged when no deadline is running. The stimulus keeps events and register writes in separate cycles, drives one request at a time from the falling edge, and sweeps the delay field over 0 to 6 so every deadline is measured as an edge count from the posting edge.

// File: rtl/wm_intr_pkg.sv
package wm_intr_pkg;
  localparam int NB = 8;
  localparam int DLY_W = NB - 1;
  localparam int B_SOFT = 0;
  localparam int B_RXH = 1;
  localparam int B_RXPKT = 2;
  localparam int B_TXL = 3;
  localparam int B_TXFULL = 6;
  localparam int B_RSVD = 7;
  localparam logic [NB-1:0] RSVD_M = NB'(1) << B_RSVD;
  localparam logic [NB-1:0] NODLY_M = (NB'(1) << B_SOFT) | (NB'(1) << B_TXFULL);
  localparam logic [NB-1:0] MASK_RST = 8'h0F;
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_CFG = 2'd2;
  localparam logic [1:0] A_CMD = 2'd3;
endpackage

// File: rtl/wm_hyst.sv
// One history flag: armed by a FIFO level, consumed by a delivery.
module wm_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic take_i,
  output logic open_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (arm_i) armed_q <= 1'b1;
    else if (take_i) armed_q <= 1'b0;
  end
  assign open_o = armed_q;
endmodule

// File: rtl/wm_defer.sv
// Deferral down-counter; a start while busy rides on the running deadline.
module wm_defer #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] load_i,
  input  logic          cancel_i,
  output logic          busy_o,
  output logic          expire_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  assign busy_o   = busy_q;
  assign expire_o = busy_q && (cnt_q == '0);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cancel_i || expire_o) begin
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= load_i;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wm_intr_ctrl.sv
module wm_intr_ctrl
  import wm_intr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_valid_i,
  input  logic [NB-1:0] evt_bits_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [NB-1:0] reg_wdata_i,
  output logic [NB-1:0] reg_rdata_o,
  input  logic          rx_empty_i,
  input  logic          tx_full_i,
  output logic          irq_o,
  output logic          bad_o
);
  logic [NB-1:0] status_q, mask_q, cfg_q;
  logic          pend_q, bad_q;
  logic          en_q;
  logic [DLY_W-1:0] dly;
  assign en_q = cfg_q[0];
  assign dly  = cfg_q[NB-1:1];

  // request decode
  logic wr_stat, wr_mask, wr_cfg, wr_cmd_soft, clr_bad, evt_bad, evt_ok, post_req;
  logic [NB-1:0] clr_bits, post_bits, st_new, mask_new, cfg_new, eff_raw, eff, gate_off;
  assign wr_stat     = reg_we_i && (reg_addr_i == A_STAT);
  assign wr_mask     = reg_we_i && (reg_addr_i == A_MASK);
  assign wr_cfg      = reg_we_i && (reg_addr_i == A_CFG);
  assign wr_cmd_soft = reg_we_i && (reg_addr_i == A_CMD) && reg_wdata_i[B_SOFT];
  assign clr_bad     = wr_stat && |(reg_wdata_i & RSVD_M);
  assign evt_bad     = evt_valid_i && |(evt_bits_i & RSVD_M);
  assign evt_ok      = evt_valid_i && !evt_bad;
  assign clr_bits    = (wr_stat && !clr_bad) ? reg_wdata_i : '0;
  assign post_bits   = (evt_ok ? evt_bits_i : '0) | (wr_cmd_soft ? (NB'(1) << B_SOFT) : '0);
  assign post_req    = evt_ok || wr_cmd_soft;
  assign st_new      = (status_q & ~clr_bits) | post_bits;
  assign mask_new    = wr_mask ? reg_wdata_i : mask_q;
  assign cfg_new     = wr_cfg ? reg_wdata_i : cfg_q;

  // watermark history gating
  logic rx_open, tx_open, post_go;
  wm_hyst u_rx_hyst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (rx_empty_i),
    .take_i (post_go && eff_raw[B_RXH] && rx_open),
    .open_o (rx_open)
  );
  wm_hyst u_tx_hyst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (tx_full_i),
    .take_i (post_go && eff_raw[B_TXL] && tx_open),
    .open_o (tx_open)
  );
  assign eff_raw  = st_new & mask_new;
  assign gate_off = (rx_open ? '0 : (NB'(1) << B_RXH)) | (tx_open ? '0 : (NB'(1) << B_TXL));
  assign eff      = eff_raw & ~gate_off;
  assign post_go  = post_req && en_q && (eff != '0);

  // scheduling
  logic post_now, post_later, mask_kick, en_kick, en_fall, fire_now, line_clr;
  logic dbusy, dexp;
  assign post_now   = post_go && ((eff & NODLY_M) != '0 || dly == '0);
  assign post_later = post_go && !post_now;
  assign mask_kick  = wr_mask && (reg_wdata_i != mask_q) && ((st_new & reg_wdata_i) != '0) && en_q;
  assign en_kick    = cfg_new[0] && !en_q && (eff_raw != '0);
  assign en_fall    = !cfg_new[0] && en_q;
  assign fire_now   = post_now || mask_kick || en_kick;
  assign line_clr   = (wr_stat && !clr_bad && (eff_raw == '0)) || en_fall;

  wm_defer #(.CW(DLY_W)) u_defer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (post_later),
    .load_i   (dly - 1'b1),
    .cancel_i (line_clr || fire_now),
    .busy_o   (dbusy),
    .expire_o (dexp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= MASK_RST;
      cfg_q    <= '0;
      pend_q   <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      status_q <= st_new;
      mask_q   <= mask_new;
      cfg_q    <= cfg_new;
      bad_q    <= clr_bad || evt_bad;
      if (line_clr) pend_q <= 1'b0;
      else if (fire_now || dexp) pend_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_STAT:  reg_rdata_o = status_q;
      A_MASK:  reg_rdata_o = mask_q;
      A_CFG:   reg_rdata_o = cfg_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = pend_q;
  assign bad_o = bad_q;
endmodule

// File: rtl/wm_intr_ctrl_chk.sv
module wm_intr_ctrl_chk
  import wm_intr_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          evt_valid_i,
  input logic [NB-1:0] evt_bits_i,
  input logic          reg_we_i,
  input logic [1:0]    reg_addr_i,
  input logic [NB-1:0] reg_wdata_i,
  input logic          irq_o,
  input logic          bad_o,
  input logic [NB-1:0] status_q,
  input logic [NB-1:0] mask_q,
  input logic          en_q,
  input logic          dbusy
);
  assert_rsvd_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && |(evt_bits_i & RSVD_M) && !reg_we_i) |=> $stable(status_q));
  assert_rsvd_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && |(evt_bits_i & RSVD_M)) |=> bad_o);
  assert_nodelay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !(|(evt_bits_i & RSVD_M)) && !reg_we_i && en_q &&
     |(evt_bits_i & mask_q & NODLY_M)) |=> irq_o);
  assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_STAT && !(|(reg_wdata_i & RSVD_M)) && !evt_valid_i)
      |=> ((status_q & $past(reg_wdata_i)) == '0));
  assert_same_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_MASK && reg_wdata_i == mask_q && !irq_o &&
     !evt_valid_i && !dbusy) |=> !irq_o);
  assert_off_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !irq_o);
endmodule

bind wm_intr_ctrl wm_intr_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_i (evt_valid_i),
  .evt_bits_i  (evt_bits_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .bad_o       (bad_o),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .en_q        (en_q),
  .dbusy       (dbusy)
);

// File: tb/wm_intr_ctrl_test.sv
`timescale 1ns/1ps
module wm_intr_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       evt_valid_i = 1'b0;
  logic [7:0] evt_bits_i = '0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       rx_empty_i = 1'b0;
  logic       tx_full_i = 1'b0;
  logic       irq_o, bad_o;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  wm_intr_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_valid_i(evt_valid_i), .evt_bits_i(evt_bits_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .rx_empty_i(rx_empty_i), .tx_full_i(tx_full_i),
    .irq_o(irq_o), .bad_o(bad_o)
  );

  localparam logic [7:0] SOFT = 8'h01, RXH = 8'h02, RXPKT = 8'h04, TXL = 8'h08, RXDMA = 8'h10;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic post(input logic [7:0] b);
    evt_valid_i = 1'b1; evt_bits_i = b;
    @(negedge clk_i);
    evt_valid_i = 1'b0; evt_bits_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr_i = a; #1; v = reg_rdata_o;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // edges from the posting edge until irq_o is seen high (99 if never)
  task automatic edges_to_irq(output int k);
    k = 0;
    while (!irq_o && k < 20) begin @(negedge clk_i); k++; end
    if (!irq_o) k = 99;
  endtask

  task automatic cfg(input int d, input bit en);
    wr(2'd2, {d[6:0], en});
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      report();
    end
  end

  initial begin
    logic [7:0] v;
    int k;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(2'd0, v); check("R1 status reset", v, 0);
    rd(2'd1, v); check("R1 mask reset", v, 8'h0F);
    rd(2'd2, v); check("R1 config reset", v, 0);
    rd(2'd3, v); check("R1 command reads zero", v, 0);
    check("R1 irq reset", irq_o, 0);

    // R10 disabled: post accumulates, no line
    post(RXPKT);
    wait_cyc(8);
    check("R10 disabled no irq", irq_o, 0);
    rd(2'd0, v); check("R1 post ORs into status", v, RXPKT);
    post(RXDMA);
    rd(2'd0, v); check("R1 second post ORs", v, RXPKT | RXDMA);
    // R10 enabling with pending effective bits fires at once
    cfg(4, 1);
    check("R10 enable kick", irq_o, 1);
    // R8 clear only written bit
    wr(2'd0, RXPKT);
    check("R8 line falls on clear", irq_o, 0);
    rd(2'd0, v); check("R8 only written bit cleared", v, RXDMA);
    wr(2'd0, 8'h7F);

    // R5 delay sweep
    for (int d = 0; d <= 6; d++) begin
      cfg(d, 1);
      post(RXPKT);
      edges_to_irq(k);
      check($sformatf("R5 delay %0d", d), k, d);
      wr(2'd0, RXPKT);
      check("R8 cleared after delay", irq_o, 0);
    end

    // R7 ride on earlier deadline
    cfg(5, 1);
    post(RXPKT);
    wait_cyc(1);
    post(RXPKT);
    edges_to_irq(k);
    check("R7 ride keeps deadline", k, 3);
    wr(2'd0, 8'h7F);

    // R8 cancel running deadline
    cfg(6, 1);
    post(RXPKT);
    wait_cyc(2);
    wr(2'd0, RXPKT);
    wait_cyc(10);
    check("R8 deadline cancelled", irq_o, 0);

    // R6 no-delay bit
    cfg(5, 1);
    post(SOFT);
    check("R6 soft immediate", irq_o, 1);
    wr(2'd0, SOFT);
    check("R8 soft cleared", irq_o, 0);
    // R11 command posts soft
    wr(2'd3, 8'h01);
    check("R11 command raises irq", irq_o, 1);
    rd(2'd0, v); check("R11 soft bit set", v, SOFT);

    // R12 pending line holds
    post(RXPKT);
    wait_cyc(8);
    check("R12 line stays high", irq_o, 1);
    wr(2'd0, SOFT);
    check("R12 held while masked status nonzero", irq_o, 1);
    wr(2'd0, RXPKT);
    check("R12 falls when zero", irq_o, 0);

    // R2 reserved event and reserved clear
    post(8'h84);
    check("R2 bad after event", bad_o, 1);
    rd(2'd0, v); check("R2 status unchanged", v, 0);
    check("R2 no irq", irq_o, 0);
    post(SOFT);
    wr(2'd0, 8'h81);
    check("R2 bad after clear", bad_o, 1);
    rd(2'd0, v); check("R2 clear ignored", v, SOFT);
    check("R2 irq kept", irq_o, 1);
    wr(2'd0, 8'h7F);

    // R9 mask behaviour
    post(RXDMA);
    wait_cyc(8);
    check("R9 masked bit no irq", irq_o, 0);
    wr(2'd1, 8'h0F);
    wait_cyc(3);
    check("R9 same mask no effect", irq_o, 0);
    wr(2'd1, 8'h1F);
    check("R9 new mask kicks", irq_o, 1);
    wr(2'd1, 8'h0F);
    wr(2'd0, RXDMA);
    check("R9 cleared", irq_o, 0);

    // R10 disable drops line, drops posts
    post(SOFT);
    cfg(5, 0);
    check("R10 disable drops line", irq_o, 0);
    rd(2'd0, v); check("R10 status kept", v, SOFT);
    post(RXPKT);
    wait_cyc(8);
    check("R10 post dropped while off", irq_o, 0);
    cfg(2, 1);
    check("R10 re-enable kicks", irq_o, 1);
    wr(2'd0, 8'h7F);

    // R3 receive-high hysteresis
    post(RXH);
    wait_cyc(8);
    check("R3 unarmed rx-high silent", irq_o, 0);
    wr(2'd0, RXH);
    rx_empty_i = 1'b1; @(negedge clk_i); rx_empty_i = 1'b0;
    post(RXH);
    edges_to_irq(k);
    check("R3 armed rx-high fires", k, 2);
    wr(2'd0, RXH);
    post(RXH);
    wait_cyc(8);
    check("R3 arming consumed", irq_o, 0);
    wr(2'd0, RXH);

    // R4 transmit-low hysteresis
    post(TXL);
    wait_cyc(8);
    check("R4 unarmed tx-low silent", irq_o, 0);
    wr(2'd0, TXL);
    tx_full_i = 1'b1; @(negedge clk_i); tx_full_i = 1'b0;
    post(TXL);
    edges_to_irq(k);
    check("R4 armed tx-low fires", k, 2);
    wr(2'd0, TXL);
    post(TXL);
    wait_cyc(8);
    check("R4 arming consumed", irq_o, 0);
    wr(2'd0, TXL);

    done = 1;
    report();
  end
endmodule